// File: doc/BRIEF.md
# Autonomous Command Sequencer with Integrity Checks

This block runs a list of front-end control commands by itself once a host starts it. Command timing then depends only on the command list, not on how busy the host processor is. Commands come in on a valid/ready stream, which a DMA channel would feed. For every command it executes, the block sends one log record out on a second, independent valid/ready stream.

There are two kinds of command: a timed wait, and a write to a small bank of control registers. The bank's outputs drive the analog front end. Two run-time checks are kept while a sequence executes: a count of the commands executed, and a CRC-8 signature over those commands. After a run, the host compares both values with what it expects.

The host uses a small write-only register port. A write to index 0 starts a sequence, and its data gives the number of commands in the list. A write to index 1 aborts a running sequence. No other write can stop a sequence once it has started. After an abort, the commands still owed by the list are drained from the input and thrown away, so the input stream stays aligned for the next run.

Top module: `cmd_sequencer`

## Requirements
- R1: After reset, the following are all zero or low: `busy`, `cmd_ready`, `res_valid`, `exec_count`, `exec_crc` and every control-bank entry.
- R2: A host write to index 0 while `busy` is low starts a run of `hreg_wdata` commands. In the next cycle `busy` is high and both `exec_count` and `exec_crc` read zero. A write to index 0 while `busy` is high is ignored.
- R3: While running, `cmd_ready` is high exactly when commands remain, no wait is pending and the log buffer has room. An accepted command takes effect on the outputs in the next cycle.
- R4: `exec_count` increases by exactly one for each executed command.
- R5: `exec_crc` is a CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value 0x00. It is fed each executed 32-bit command most-significant byte first, and each byte most-significant bit first.
- R6: A command with bit 31 set is a wait, and bits 29:0 give its length L (bit 30 is ignored). `cmd_ready` stays low for the L cycles after the wait is accepted. When L is 0 there is no stall.
- R7: A command with bit 31 clear is a register write. Bits 23:16 give the entry index and bits 15:0 give the value, which appears on `ctrl_bank[16*i +: 16]` in the next cycle. An index of NREG or above changes no entry, but the command is still counted and signed.
- R8: A host write to index 1 while a sequence is running ends it in the next cycle and drops any pending wait. A command accepted in that same cycle is discarded: it is not counted, not signed, not written and not logged. A write to index 1 while no sequence is running has no effect.
- R9: After an abort, the commands still owed by the list are accepted with `cmd_ready` high and thrown away. `busy` falls once none remain.
- R10: Host writes to indices other than 0 and 1 have no effect on a running sequence.
- R11: `exec_count` and `exec_crc` keep their final values after a sequence ends or is aborted, until the next start.
- R12: Each executed command emits one record on `res_data`. The record holds the wait flag in bit 31, zeros in bits 30:24, the CRC after the command in bits 23:16 and the count after the command in bits 15:0. Records leave in order and hold steady while `res_ready` is low. When the log buffer is full, `cmd_ready` goes low.
- R13: A normal run ends, and `busy` falls, one cycle after the last command has been executed and its wait has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreg_we | input | 1 | Host register write strobe |
| hreg_addr | input | HADDR_W | Host register index (0 start, 1 abort) |
| hreg_wdata | input | RUN_W | Host write data (command count for start) |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_data | input | 32 | Command word |
| res_valid | output | 1 | Log stream valid |
| res_ready | input | 1 | Log stream ready |
| res_data | output | 32 | Log record |
| busy | output | 1 | Sequence running or draining after abort |
| exec_count | output | CNT_W | Executed command count |
| exec_crc | output | 8 | CRC-8 signature of executed commands |
| ctrl_bank | output | NREG*16 | Control register bank, entry i at bits 16*i+15:16*i |

## Verification
The hard case is when a host abort lands in the same cycle that a command is accepted. The abort must win, and the accepted beat must be counted toward the drain but never executed. The bench waits until the reference model shows `cmd_ready` high with a command waiting and exactly one command already done, and then issues the abort. It judges the result from the count, the untouched bank entry and the absence of a second log record. A second overlap arises when the log buffer fills while commands are still arriving. With `res_ready` held low, command intake must stop after the buffer plus the output register are full, and it must resume without loss or reordering once the stream drains.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int CMD_W    = 32;
  localparam int WAIT_BIT = 31;
  localparam int LEN_W    = 30;
  localparam int IDX_HI   = 23;
  localparam int IDX_LO   = 16;
  localparam int REG_DW   = 16;
  localparam int CRC_W    = 8;
  localparam int LOG_W    = 32;
  localparam int LOG_CNT_W = 16;

  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  localparam int HOST_RUN_IDX   = 0;
  localparam int HOST_ABORT_IDX = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH
  } seq_state_e;

  // Bit-serial CRC-8, MSB of the word first (same as MSB byte first).
  function automatic logic [CRC_W-1:0] crc8_word(input logic [CRC_W-1:0] seed,
                                                 input logic [CMD_W-1:0] word);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = seed;
    for (int i = CMD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/seq_hostif.sv
module seq_hostif
  import seq_pkg::*;
#(
  parameter int HADDR_W = 4,
  parameter int RUN_W   = 16
) (
  input  logic               we,
  input  logic [HADDR_W-1:0] addr,
  input  logic [RUN_W-1:0]   wdata,
  input  logic               busy,
  input  logic               running,
  output logic               run_req,
  output logic               abort_req,
  output logic [RUN_W-1:0]   run_len
);

  localparam logic [HADDR_W-1:0] RUN_A   = HADDR_W'(HOST_RUN_IDX);
  localparam logic [HADDR_W-1:0] ABORT_A = HADDR_W'(HOST_ABORT_IDX);

  always_comb begin
    run_req   = we && (addr == RUN_A) && !busy;
    abort_req = we && (addr == ABORT_A) && running;
    run_len   = wdata;
  end

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int RUN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_req,
  input  logic [RUN_W-1:0]   run_len,
  input  logic               abort_req,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_data,
  input  logic               log_full,
  output logic               running,
  output logic               busy,
  output logic               exec_fire,
  output logic [LOG_W-1:0]   log_word,
  output logic [CNT_W-1:0]   count,
  output logic [CRC_W-1:0]   crc
);

  seq_state_e        state_q;
  logic [RUN_W-1:0]  remain_q;
  logic [LEN_W-1:0]  wait_q;
  logic [CNT_W-1:0]  count_q;
  logic [CRC_W-1:0]  crc_q;

  logic              hs;
  logic              rem_nz;
  logic [RUN_W-1:0]  remain_after;
  logic [CNT_W-1:0]  count_next;
  logic [CRC_W-1:0]  crc_next;
  logic              is_wait;

  always_comb begin
    rem_nz       = (remain_q != '0);
    cmd_ready    = rem_nz &&
                   (((state_q == ST_RUN) && (wait_q == '0) && !log_full) ||
                    (state_q == ST_FLUSH));
    hs           = cmd_valid && cmd_ready;
    exec_fire    = hs && (state_q == ST_RUN) && !abort_req;
    remain_after = remain_q - RUN_W'(hs);
    count_next   = count_q + CNT_W'(1);
    crc_next     = crc8_word(crc_q, cmd_data);
    is_wait      = cmd_data[WAIT_BIT];
    log_word     = {is_wait, 7'b0, crc_next, LOG_CNT_W'(count_next)};
    running      = (state_q == ST_RUN);
    busy         = (state_q != ST_IDLE);
    count        = count_q;
    crc          = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      wait_q   <= '0;
      count_q  <= '0;
      crc_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (run_req) begin
            state_q  <= ST_RUN;
            remain_q <= run_len;
            wait_q   <= '0;
            count_q  <= '0;
            crc_q    <= '0;
          end
        end
        ST_RUN: begin
          if (abort_req) begin
            wait_q   <= '0;
            remain_q <= remain_after;
            state_q  <= (remain_after != '0) ? ST_FLUSH : ST_IDLE;
          end else if (exec_fire) begin
            remain_q <= remain_after;
            count_q  <= count_next;
            crc_q    <= crc_next;
            wait_q   <= is_wait ? cmd_data[LEN_W-1:0] : '0;
          end else if (wait_q != '0) begin
            wait_q <= wait_q - LEN_W'(1);
          end else if (!rem_nz) begin
            state_q <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (hs) remain_q <= remain_after;
          else if (!rem_nz) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seq_ctrl_bank.sv
module seq_ctrl_bank
  import seq_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_HI-IDX_LO:0] wr_idx,
  input  logic [REG_DW-1:0]      wr_val,
  output logic [NREG*REG_DW-1:0] bank
);

  localparam int IDX_W = IDX_HI - IDX_LO + 1;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic [REG_DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g))) q <= wr_val;
    end
    assign bank[g*REG_DW +: REG_DW] = q;
  end

endmodule

// File: rtl/seq_log_fifo.sv
module seq_log_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   occ;
  logic          pop;

  always_comb begin
    full = (occ == (AW+1)'(DEPTH));
    pop  = (!out_valid || out_ready) && (occ != '0);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      occ <= occ + (AW+1)'(push) - (AW+1)'(pop);
      if (pop) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import seq_pkg::*;
#(
  parameter int HADDR_W   = 4,
  parameter int RUN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int NREG      = 8,
  parameter int LOG_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hreg_we,
  input  logic [HADDR_W-1:0]     hreg_addr,
  input  logic [RUN_W-1:0]       hreg_wdata,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [31:0]            cmd_data,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [31:0]            res_data,
  output logic                   busy,
  output logic [CNT_W-1:0]       exec_count,
  output logic [7:0]             exec_crc,
  output logic [NREG*16-1:0]     ctrl_bank
);

  logic             run_req, abort_req, run_active, exec_fire, log_full;
  logic [RUN_W-1:0] run_len;
  logic [LOG_W-1:0] log_word;

  seq_hostif #(.HADDR_W(HADDR_W), .RUN_W(RUN_W)) u_host (
    .we(hreg_we), .addr(hreg_addr), .wdata(hreg_wdata),
    .busy(busy), .running(run_active),
    .run_req(run_req), .abort_req(abort_req), .run_len(run_len)
  );

  seq_core #(.RUN_W(RUN_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run_req(run_req), .run_len(run_len),
    .abort_req(abort_req), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .log_full(log_full), .running(run_active),
    .busy(busy), .exec_fire(exec_fire), .log_word(log_word),
    .count(exec_count), .crc(exec_crc)
  );

  seq_ctrl_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(exec_fire && !cmd_data[WAIT_BIT]),
    .wr_idx(cmd_data[IDX_HI:IDX_LO]),
    .wr_val(cmd_data[REG_DW-1:0]),
    .bank(ctrl_bank)
  );

  seq_log_fifo #(.W(LOG_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk(clk), .rst(rst), .push(exec_fire), .push_data(log_word),
    .full(log_full), .out_valid(res_valid), .out_ready(res_ready),
    .out_data(res_data)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int HADDR_W = 4,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               hreg_we,
  input logic [HADDR_W-1:0] hreg_addr,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [31:0]        cmd_data,
  input logic               res_valid,
  input logic               res_ready,
  input logic [31:0]        res_data,
  input logic               busy,
  input logic [CNT_W-1:0]   exec_count,
  input logic [7:0]         exec_crc,
  input logic               run_active
);

  logic start_w, abort_w, take_w;
  assign start_w = hreg_we && (hreg_addr == HADDR_W'(0)) && !busy;
  assign abort_w = hreg_we && (hreg_addr == HADDR_W'(1)) && run_active;
  assign take_w  = cmd_valid && cmd_ready && run_active && !abort_w;

  assert_idle_no_ready_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_ready);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    start_w |=> (run_active && exec_count == '0 && exec_crc == '0));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    take_w |=> (exec_count == $past(exec_count) + CNT_W'(1)));

  assert_wait_stalls_R6: assert property (@(posedge clk) disable iff (rst)
    (take_w && cmd_data[31] && cmd_data[29:0] != '0) |=> !cmd_ready);

  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> !run_active);

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!run_active && !start_w) |=> ($stable(exec_count) && $stable(exec_crc)));

  assert_log_stable_R12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

endmodule

bind cmd_sequencer seq_checker #(.HADDR_W(HADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hreg_we(hreg_we), .hreg_addr(hreg_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .busy(busy), .exec_count(exec_count), .exec_crc(exec_crc),
  .run_active(run_active)
);

// File: tb/sim_cmd_sequencer.sv
module sim_cmd_sequencer;

  localparam int NREG  = 8;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         hreg_we = 1'b0;
  logic [3:0]   hreg_addr = '0;
  logic [15:0]  hreg_wdata = '0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_data = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [31:0]  res_data;
  logic         busy;
  logic [15:0]  exec_count;
  logic [7:0]   exec_crc;
  logic [NREG*16-1:0] ctrl_bank;

  always #5 clk = ~clk;

  cmd_sequencer u0 (
    .clk(clk), .rst(rst), .hreg_we(hreg_we), .hreg_addr(hreg_addr),
    .hreg_wdata(hreg_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .busy(busy), .exec_count(exec_count),
    .exec_crc(exec_crc), .ctrl_bank(ctrl_bank)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  int          m_state = 0;   // 0 idle, 1 running, 2 draining
  int          m_remain = 0;
  int          m_wait = 0;
  logic [15:0] m_count = '0;
  logic [7:0]  m_crc = '0;
  logic [15:0] m_bank [NREG];
  int          m_occ = 0;
  bit          m_ov = 0;
  logic [31:0] exp_log [$];
  logic [31:0] stim [$];

  bit          h_we = 0;
  logic [3:0]  h_addr = '0;
  logic [15:0] h_wd = '0;
  bit          feed_en = 1;
  int          rr_mode = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c0, input logic [31:0] w);
    logic [7:0] c;
    c = c0;
    for (int b = 3; b >= 0; b--) begin
      c = c ^ w[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] wr(input int idx, input logic [15:0] v);
    return {8'h00, 8'(idx), v};
  endfunction

  function automatic logic [31:0] wt(input int len);
    return {2'b10, 30'(len)};
  endfunction

  function automatic bit m_ready();
    return (m_remain != 0) &&
           ((m_state == 1 && m_wait == 0 && m_occ < DEPTH) || m_state == 2);
  endfunction

  function automatic logic [NREG*16-1:0] m_bank_flat();
    logic [NREG*16-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*16 +: 16] = m_bank[i];
    return f;
  endfunction

  task automatic step();
    bit rdy, hs, abort, runq, exec, pop;
    logic [7:0] nc;
    logic [15:0] ncnt;
    hreg_we    = h_we;
    hreg_addr  = h_addr;
    hreg_wdata = h_wd;
    h_we       = 0;
    cmd_valid  = feed_en && (stim.size() > 0);
    cmd_data   = (stim.size() > 0) ? stim[0] : 32'h0;
    res_ready  = (rr_mode == 0) ? 1'b1 : (rr_mode == 1) ? 1'b0 : cyc[0];
    if (res_valid && res_ready) begin
      if (exp_log.size() == 0) chk("R12 unexpected record", res_data, 128'hx);
      else chk("R12 record content", res_data, exp_log.pop_front());
    end
    rdy   = m_ready();
    hs    = cmd_valid && rdy;
    abort = hreg_we && hreg_addr == 4'd1 && m_state == 1;
    runq  = hreg_we && hreg_addr == 4'd0 && m_state == 0;
    exec  = hs && m_state == 1 && !abort;
    pop   = (!m_ov || res_ready) && m_occ > 0;
    nc    = ref_crc(m_crc, cmd_data);
    ncnt  = m_count + 16'd1;
    if (exec) begin
      exp_log.push_back({cmd_data[31], 7'b0, nc, ncnt});
      if (!cmd_data[31] && cmd_data[23:16] < NREG) m_bank[cmd_data[23:16]] = cmd_data[15:0];
    end
    m_occ = m_occ + int'(exec) - int'(pop);
    m_ov  = pop ? 1'b1 : (res_ready ? 1'b0 : m_ov);
    case (m_state)
      0: if (runq) begin
        m_state = 1; m_remain = hreg_wdata; m_count = 0; m_crc = 0; m_wait = 0;
      end
      1: if (abort) begin
        m_wait = 0; m_remain = m_remain - int'(hs);
        m_state = (m_remain != 0) ? 2 : 0;
      end else if (exec) begin
        m_remain--; m_count = ncnt; m_crc = nc;
        m_wait = cmd_data[31] ? int'(cmd_data[29:0]) : 0;
      end else if (m_wait != 0) m_wait--;
      else if (m_remain == 0) m_state = 0;
      default: if (hs) m_remain--;
      else if (m_remain == 0) m_state = 0;
    endcase
    if (hs) void'(stim.pop_front());
    @(negedge clk);
    cyc++;
    chk("R3 cmd_ready", cmd_ready, rdy ? m_ready() : m_ready());
    chk("R13 busy", busy, m_state != 0);
    chk("R4 exec_count", exec_count, m_count);
    chk("R5 exec_crc", exec_crc, m_crc);
    chk("R7 ctrl_bank", ctrl_bank, m_bank_flat());
    chk("R12 res_valid", res_valid, m_ov);
  endtask

  task automatic host(input int a, input int d);
    h_we = 1; h_addr = 4'(a); h_wd = 16'(d);
    step();
  endtask

  task automatic run_to_idle();
    for (int i = 0; i < 3000 && m_state != 0; i++) step();
    for (int i = 0; i < 30; i++) step();
  endtask

  logic [7:0] saved_crc;

  initial begin
    for (int i = 0; i < NREG; i++) m_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 cmd_ready", cmd_ready, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 count", exec_count, 0);
    chk("R1 crc", exec_crc, 0);
    chk("R1 bank", ctrl_bank, 0);

    // normal run with wait and out-of-range index
    rr_mode = 2;
    stim = '{wr(0, 16'h1111), wr(1, 16'h2222), wt(3), wr(7, 16'habcd), wr(9, 16'h5555)};
    host(0, 5);
    chk("R2 busy after start", busy, 1);
    chk("R2 count cleared", exec_count, 0);
    host(0, 2);   // ignored restart
    host(5, 0);   // R10 ordinary write
    chk("R10 still running", busy, 1);
    run_to_idle();
    chk("R2 restart ignored count", exec_count, 5);
    chk("R7 entry0", ctrl_bank[15:0], 16'h1111);
    chk("R7 entry7", ctrl_bank[7*16 +: 16], 16'habcd);
    saved_crc = ref_crc(ref_crc(ref_crc(ref_crc(ref_crc(8'h0, wr(0, 16'h1111)),
                wr(1, 16'h2222)), wt(3)), wr(7, 16'habcd)), wr(9, 16'h5555));
    chk("R5 signature", exec_crc, saved_crc);
    for (int i = 0; i < 10; i++) step();
    chk("R11 count held", exec_count, 5);
    chk("R11 crc held", exec_crc, saved_crc);

    // zero-length wait and a stalling wait
    rr_mode = 0;
    stim = '{wt(0), wr(1, 16'h0101), wt(4), wr(2, 16'h0202)};
    host(0, 4);
    for (int i = 0; i < 50 && m_wait == 0; i++) step();
    chk("R6 ready low during wait", cmd_ready, 0);
    run_to_idle();
    chk("R6 count after waits", exec_count, 4);

    // abort during a long wait, then drain
    stim = '{wr(2, 16'h7777), wt(40), wr(3, 16'h0bad), wr(3, 16'h0bad), wr(4, 16'h0bad)};
    host(0, 5);
    for (int i = 0; i < 50 && m_wait == 0; i++) step();
    repeat (5) step();
    host(1, 0);
    chk("R8 running ended", cmd_ready, 1);
    run_to_idle();
    chk("R8 count after abort", exec_count, 2);
    chk("R9 drained", stim.size(), 0);
    chk("R9 entry3 untouched", ctrl_bank[3*16 +: 16], 0);
    chk("R7 entry2", ctrl_bank[2*16 +: 16], 16'h7777);

    // abort in the same cycle as an accept
    stim = '{wr(4, 16'h4444), wr(5, 16'h5555), wr(6, 16'h6666)};
    host(0, 3);
    for (int i = 0; i < 50 && !(m_ready() && m_count == 1); i++) step();
    host(1, 0);
    run_to_idle();
    chk("R8 same-cycle accept dropped", exec_count, 1);
    chk("R8 entry5 untouched", ctrl_bank[5*16 +: 16], 0);
    chk("R8 entry4", ctrl_bank[4*16 +: 16], 16'h4444);
    chk("R12 no extra record", exp_log.size(), 0);

    // idle abort, empty run
    host(1, 0);
    chk("R8 idle abort ignored", busy, 0);
    host(0, 0);
    run_to_idle();
    chk("R2 empty run count", exec_count, 0);
    chk("R2 empty run crc", exec_crc, 0);

    // backpressure from a full log
    rr_mode = 1;
    for (int i = 0; i < 12; i++) stim.push_back(wr(6, 16'(16'h100 + i)));
    host(0, 12);
    repeat (40) step();
    chk("R12 intake stops when full", exec_count, DEPTH + 1);
    chk("R12 ready low when full", cmd_ready, 0);
    rr_mode = 2;
    run_to_idle();
    chk("R12 all executed", exec_count, 12);
    chk("R12 log drained", exp_log.size(), 0);
    chk("R7 entry6", ctrl_bank[6*16 +: 16], 16'h10b);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule